// File: doc/BRIEF.md
# Coherent Cache Line Request Controller

This block follows the coherency state of one cache line owned by a caching master on a coherent interconnect. When the master presents a load or store command, the controller chooses which coherent read, ownership or write transaction to send. It takes this choice from the line's present state and from the command's attributes: shareable or not, full or partial line, whether the requester has a cache, and which load flavour is preferred. The chosen transaction leaves on a valid/ready channel. When the interconnect's response handshake completes, the controller derives the line's new state from the IsShared and PassDirty bits of the 4-bit read response.

Only one transaction may be in flight. Further commands are held off with `cmd_ready` until the response arrives. A store that hits a line already held uniquely needs no transaction, and the line moves straight to UniqueDirty. Read requests may be speculative, meaning they can be sent while the line is already valid. Dirtiness the line already holds is kept across such a read. A response that breaks the limits of the request raises a one-cycle protocol error and leaves the state unchanged.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line state is I, `cmd_ready` is 1, `txn_valid` is 0 and `proto_err` is 0. Line state codes: I=0, UC=1, UD=2, SC=3, SD=4.
- R2: A load from a shareable location by a cached master selects the transaction from `cmd_pref`: 0 gives ReadShared (code 4), 1 gives ReadClean (code 2), 2 gives ReadNotSharedDirty (code 3), 3 gives ReadOnce (code 1).
- R3: A load from a non-shareable location gives ReadNoSnoop (code 0). A shareable load from a master without a cache gives ReadOnce (code 1).
- R4: A store to a shareable location by a cached master gives one of three transactions. With the line in I, it is MakeUnique (code 7) for a full line and ReadUnique (code 5) for a partial line. With the line in SC or SD, it is CleanUnique (code 6).
- R5: A cached shareable store while the line is UC or UD is accepted without a transaction, and the line state is UD on the next cycle.
- R6: A store to a non-shareable location gives WriteNoSnoop (code 8). A shareable store from a master without a cache gives WriteUnique (code 9) for a partial line and WriteLineUnique (code 10) for a full line.
- R7: After ReadShared, ReadClean or ReadNotSharedDirty without error, response bit 3 (IsShared) selects SC/SD when 1 and UC/UD when 0. The line is dirty when bit 2 (PassDirty) is 1 or the line was already dirty. Bits 1:0 have no effect.
- R8: After ReadUnique, CleanUnique or MakeUnique, the line becomes UD. If IsShared is 1 in that response, it is a protocol error.
- R9: A protocol error is flagged in three cases: ReadClean with PassDirty=1, ReadNotSharedDirty with IsShared=1 and PassDirty=1, or the R8 case. Then `proto_err` is 1 for exactly the cycle after the response handshake, and the line state keeps its prior value.
- R10: ReadNoSnoop, ReadOnce and all write transactions leave the line state unchanged.
- R11: From command acceptance until the response handshake, `cmd_ready` is 0, and a command presented during that time is ignored.
- R12: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid` stays 1 and `txn_type` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command taken |
| cmd_is_store | input | 1 | 1 = store, 0 = load |
| cmd_shareable | input | 1 | Target location is shareable |
| cmd_full_line | input | 1 | Store covers the whole line |
| cmd_has_cache | input | 1 | Requesting master holds a cache |
| cmd_pref | input | 2 | Load flavour preference (see R2) |
| txn_valid | output | 1 | Transaction request present |
| txn_ready | input | 1 | Interconnect takes the transaction |
| txn_type | output | 4 | Transaction code (see R2-R6) |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Controller awaiting a response |
| rsp_resp | input | 4 | Read response; bit 3 IsShared, bit 2 PassDirty |
| line_state | output | 3 | Current line state code (see R1) |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
A wrong internal line state shows up at the ports in two ways. The next store chooses the wrong ownership transaction, or wrongly skips it. The line state itself is also visible one cycle after the response handshake that wrote it. The bench starts the line in each of the five states. It applies every command attribute combination and every IsShared/PassDirty pair, with junk in the low response bits. It checks the transaction code as soon as it is offered, and the end state and error pulse on the first cycle after the response. A stuck busy phase appears at once as `cmd_ready` staying low, or as a stray command being taken.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

    localparam int STATE_W = 3;
    localparam int TXN_W   = 4;
    localparam int PREF_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        LN_I  = 3'd0,
        LN_UC = 3'd1,
        LN_UD = 3'd2,
        LN_SC = 3'd3,
        LN_SD = 3'd4
    } line_st_e;

    typedef enum logic [TXN_W-1:0] {
        TX_RD_NOSNP   = 4'd0,
        TX_RD_ONCE    = 4'd1,
        TX_RD_CLEAN   = 4'd2,
        TX_RD_NSD     = 4'd3,
        TX_RD_SHARED  = 4'd4,
        TX_RD_UNIQUE  = 4'd5,
        TX_CLN_UNIQUE = 4'd6,
        TX_MK_UNIQUE  = 4'd7,
        TX_WR_NOSNP   = 4'd8,
        TX_WR_UNIQUE  = 4'd9,
        TX_WR_LINE    = 4'd10
    } txn_e;

    typedef enum logic [PREF_W-1:0] {
        PREF_ANY    = 2'd0,
        PREF_CLEAN  = 2'd1,
        PREF_NSD    = 2'd2,
        PREF_NOKEEP = 2'd3
    } pref_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic  is_store;
        logic  shareable;
        logic  full_line;
        logic  has_cache;
        pref_e pref;
    } cmd_t;

    function automatic logic st_dirty(line_st_e s);
        return (s == LN_UD) || (s == LN_SD);
    endfunction

    function automatic logic st_unique(line_st_e s);
        return (s == LN_UC) || (s == LN_UD);
    endfunction

    function automatic line_st_e st_make(logic shared, logic dirty);
        line_st_e r;
        unique case ({shared, dirty})
            2'b00:   r = LN_UC;
            2'b01:   r = LN_UD;
            2'b10:   r = LN_SC;
            default: r = LN_SD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/coh_req_select.sv
module coh_req_select
    import coh_line_pkg::*;
(
    input  cmd_t     cmd,
    input  line_st_e cur,
    output txn_e     txn,
    output logic     store_hit
);

    always_comb begin
        txn       = TX_RD_NOSNP;
        store_hit = 1'b0;
        if (!cmd.is_store) begin
            if (!cmd.shareable) begin
                txn = TX_RD_NOSNP;
            end else if (!cmd.has_cache) begin
                txn = TX_RD_ONCE;
            end else begin
                unique case (cmd.pref)
                    PREF_ANY:   txn = TX_RD_SHARED;
                    PREF_CLEAN: txn = TX_RD_CLEAN;
                    PREF_NSD:   txn = TX_RD_NSD;
                    default:    txn = TX_RD_ONCE;
                endcase
            end
        end else begin
            if (!cmd.shareable) begin
                txn = TX_WR_NOSNP;
            end else if (!cmd.has_cache) begin
                txn = cmd.full_line ? TX_WR_LINE : TX_WR_UNIQUE;
            end else if (st_unique(cur)) begin
                store_hit = 1'b1;
            end else if (cur == LN_I) begin
                txn = cmd.full_line ? TX_MK_UNIQUE : TX_RD_UNIQUE;
            end else begin
                txn = TX_CLN_UNIQUE;
            end
        end
    end

endmodule

// File: rtl/coh_resp_resolve.sv
module coh_resp_resolve
    import coh_line_pkg::*;
(
    input  txn_e     kind,
    input  line_st_e cur,
    input  logic     is_shared,
    input  logic     pass_dirty,
    output line_st_e nxt,
    output logic     err,
    output logic     alloc_read,
    output logic     own_req
);

    always_comb begin
        nxt        = cur;
        err        = 1'b0;
        alloc_read = 1'b0;
        own_req    = 1'b0;
        unique case (kind)
            TX_RD_SHARED, TX_RD_CLEAN, TX_RD_NSD: begin
                alloc_read = 1'b1;
                err = ((kind == TX_RD_CLEAN) && pass_dirty) ||
                      ((kind == TX_RD_NSD) && is_shared && pass_dirty);
                if (!err) begin
                    nxt = st_make(is_shared, pass_dirty | st_dirty(cur));
                end
            end
            TX_RD_UNIQUE, TX_CLN_UNIQUE, TX_MK_UNIQUE: begin
                own_req = 1'b1;
                err     = is_shared;
                if (!err) begin
                    nxt = LN_UD;
                end
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_line_pkg::*;
#(
    parameter int RESP_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_is_store,
    input  logic                cmd_shareable,
    input  logic                cmd_full_line,
    input  logic                cmd_has_cache,
    input  logic [PREF_W-1:0]   cmd_pref,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [TXN_W-1:0]    txn_type,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [RESP_W-1:0]   rsp_resp,
    output logic [STATE_W-1:0]  line_state,
    output logic                proto_err
);

    localparam int SHARED_BIT = RESP_W - 1;
    localparam int PDIRTY_BIT = RESP_W - 2;

    typedef struct packed {
        phase_e   phase;
        txn_e     txn;
        line_st_e line;
        logic     err;
    } regs_t;

    regs_t    r_d, r_q;
    cmd_t     cmd_in;
    txn_e     sel_txn;
    logic     sel_hit;
    line_st_e res_nxt;
    logic     res_err, res_alloc, res_own;
    logic     unused_resp_low;

    assign cmd_in = '{is_store:  cmd_is_store,
                      shareable: cmd_shareable,
                      full_line: cmd_full_line,
                      has_cache: cmd_has_cache,
                      pref:      pref_e'(cmd_pref)};

    assign unused_resp_low = ^rsp_resp[PDIRTY_BIT-1:0];

    coh_req_select i_sel (
        .cmd       (cmd_in),
        .cur       (r_q.line),
        .txn       (sel_txn),
        .store_hit (sel_hit)
    );

    coh_resp_resolve i_res (
        .kind       (r_q.txn),
        .cur        (r_q.line),
        .is_shared  (rsp_resp[SHARED_BIT]),
        .pass_dirty (rsp_resp[PDIRTY_BIT]),
        .nxt        (res_nxt),
        .err        (res_err),
        .alloc_read (res_alloc),
        .own_req    (res_own)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (sel_hit) begin
                        r_d.line = LN_UD;
                    end else begin
                        r_d.txn   = sel_txn;
                        r_d.phase = PH_ISSUE;
                    end
                end
            end
            PH_ISSUE: begin
                if (txn_ready) begin
                    r_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (rsp_valid) begin
                    r_d.line  = res_nxt;
                    r_d.err   = res_err;
                    r_d.phase = PH_IDLE;
                end
            end
            default: begin
                r_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, txn: TX_RD_NOSNP, line: LN_I, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready  = (r_q.phase == PH_IDLE);
    assign txn_valid  = (r_q.phase == PH_ISSUE);
    assign rsp_ready  = (r_q.phase == PH_WAIT);
    assign txn_type   = r_q.txn;
    assign line_state = r_q.line;
    assign proto_err  = r_q.err;

    p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_state <= 3'd4);

    p_issue_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !sel_hit) |=> (txn_valid && !cmd_ready));

    p_hit_to_ud_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && sel_hit) |=> (line_state == 3'd2 && !txn_valid));

    p_txn_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_type)));

    p_shared_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && res_alloc && !res_err && rsp_resp[SHARED_BIT])
        |=> (line_state == 3'd3 || line_state == 3'd4));

    p_own_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && res_own && !res_err) |=> (line_state == 3'd2));

    p_err_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && res_err) |=> (proto_err && $stable(line_state)));

    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

endmodule

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/1ps
module test_coh_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_ready;
    logic       cmd_is_store = 1'b0, cmd_shareable = 1'b0;
    logic       cmd_full_line = 1'b0, cmd_has_cache = 1'b0;
    logic [1:0] cmd_pref = 2'd0;
    logic       txn_valid, txn_ready = 1'b0;
    logic [3:0] txn_type;
    logic       rsp_valid = 1'b0, rsp_ready;
    logic [3:0] rsp_resp = 4'd0;
    logic [2:0] line_state;
    logic       proto_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    coh_line_ctrl i_coh_line_ctrl (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_is_store, .cmd_shareable,
        .cmd_full_line, .cmd_has_cache, .cmd_pref, .txn_valid, .txn_ready,
        .txn_type, .rsp_valid, .rsp_ready, .rsp_resp, .line_state, .proto_err
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model of the requirements: transaction code, or -1 for a store hit
    function automatic int exp_txn(int s, bit st, bit sh, bit fl, bit hc, int pf);
        if (!st) begin
            if (!sh) return 0;
            if (!hc) return 1;
            case (pf)
                0: return 4;
                1: return 2;
                2: return 3;
                default: return 1;
            endcase
        end
        if (!sh) return 8;
        if (!hc) return fl ? 10 : 9;
        if (s == 1 || s == 2) return -1;
        if (s == 0) return fl ? 7 : 5;
        return 6;
    endfunction

    function automatic int mk_state(bit shared, bit dirty);
        if (shared) return dirty ? 4 : 3;
        return dirty ? 2 : 1;
    endfunction

    task automatic drive_cmd(bit st, bit sh, bit fl, bit hc, int pf);
        cmd_is_store  = st;
        cmd_shareable = sh;
        cmd_full_line = fl;
        cmd_has_cache = hc;
        cmd_pref      = 2'(pf);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0; txn_ready = 1'b0; rsp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Bring the line from I to state s with a ReadShared (R7 path)
    task automatic set_state(int s);
        do_reset();
        if (s != 0) begin
            drive_cmd(1'b0, 1'b1, 1'b0, 1'b1, 0);
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            txn_ready = 1'b1;
            @(negedge clk);
            txn_ready = 1'b0;
            rsp_valid = 1'b1;
            rsp_resp  = {(s >= 3) ? 1'b1 : 1'b0, (s == 2 || s == 4) ? 1'b1 : 1'b0, 2'b00};
            @(negedge clk);
            rsp_valid = 1'b0;
        end
        check(line_state == 3'(s), "R7 setup", line_state, s);
    endtask

    task automatic run_case(int s, bit st, bit sh, bit fl, bit hc, int pf,
                            bit is, bit pd, logic [1:0] junk, bit hold);
        int    et;
        int    es;
        bit    ee;
        string ttag;
        string stag;
        et = exp_txn(s, st, sh, fl, hc, pf);
        es = s;
        ee = 1'b0;
        stag = "R10";
        if (et == 2 || et == 3 || et == 4) begin
            stag = "R7";
            ee = (et == 2 && pd) || (et == 3 && is && pd);
            if (!ee) es = mk_state(is, pd | (s == 2) | (s == 4));
        end else if (et == 5 || et == 6 || et == 7) begin
            stag = "R8";
            ee = is;
            if (!ee) es = 2;
        end
        if (!st) ttag = (sh && hc && pf != 3) ? "R2" : "R3";
        else     ttag = (sh && hc) ? "R4" : "R6";

        drive_cmd(st, sh, fl, hc, pf);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (et < 0) begin
            check(!txn_valid, "R5 no txn", txn_valid, 0);
            check(line_state == 3'd2, "R5 state", line_state, 2);
            check(cmd_ready, "R5 ready", cmd_ready, 1);
            return;
        end
        check(txn_valid, {ttag, " valid"}, txn_valid, 1);
        check(txn_type == 4'(et), ttag, txn_type, et);
        check(!cmd_ready, "R11 busy", cmd_ready, 0);
        if (hold) begin
            @(negedge clk);
            check(txn_valid && txn_type == 4'(et), "R12 hold", txn_type, et);
        end
        txn_ready = 1'b1;
        @(negedge clk);
        txn_ready = 1'b0;
        check(!txn_valid && rsp_ready, "R11 wait", {txn_valid, rsp_ready}, 1);
        // stray command while busy must be ignored (R11)
        drive_cmd(1'b1, 1'b1, 1'b1, 1'b1, 0);
        cmd_valid = 1'b1;
        rsp_valid = 1'b1;
        rsp_resp  = {is, pd, junk};
        @(negedge clk);
        rsp_valid = 1'b0;
        cmd_valid = 1'b0;
        check(line_state == 3'(es), stag, line_state, es);
        check(proto_err == ee, "R9 err", proto_err, ee);
        check(cmd_ready, "R11 free", cmd_ready, 1);
        @(negedge clk);
        check(!proto_err, "R9 pulse", proto_err, 0);
        check(!txn_valid && line_state == 3'(es), "R11 stray ignored", line_state, es);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        check(line_state == 3'd0, "R1 state", line_state, 0);
        check(cmd_ready && !txn_valid && !rsp_ready, "R1 handshake",
              {cmd_ready, txn_valid, rsp_ready}, 4);
        check(!proto_err, "R1 err", proto_err, 0);
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 64; c++) begin
                for (int r = 0; r < 4; r++) begin
                    set_state(s);
                    run_case(s, c[5], c[4], c[3], c[2], c[1:0] + 0,
                             r[1], r[0], 2'(c + r), (c[0] ^ r[0]) == 1'b1);
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule